// File: doc/BRIEF.md
# Clock Output Enable and Power-Down Controller

This block decides, for each of several differential clock outputs and one single-ended reference output, whether the output toggles, is held low, or is not driven at all. It runs on the output clock itself. Asynchronous pins pass through two-flop synchronizers on the rising edge. Every run decision is registered on the falling edge, so a clock pulse is never cut short or stretched. The inputs are per-output active-low enable pins, per-output register enable bits, a combined power-good / power-down pin, a PLL lock flag, and the reference control bits. The outputs are a run flag per lane, a run flag and a drive enable for the reference, and the resolved spread-spectrum setting.

The first high level of the power-good pin does two things. It captures the tri-level spread strap and marks the block as started. From then on the reference output is driven, and the same pin only enters and leaves power-down. The spread setting that is applied comes from the captured strap, unless a software override enable selects a software code instead.

Top module: `ckout_pm_ctrl`

## Requirements
- R1: Until the synchronized `pwr_ok` is first seen high after reset, the outputs are held in their idle state: `ref_drive`=0 (not driven), `ref_run`=0, `dif_run`=0 and `ss_readback`=00.
- R2: The first synchronized high of `pwr_ok` sets `ref_drive`=1, which stays 1 until `rst_n` is asserted. The same event captures `ss_strap`. Later changes of the strap, or later power-good cycles, do not change `ss_readback`.
- R3: Lane i runs (`dif_run[i]`=1) only when all of the following hold: the block has started, the synchronized `pwr_ok` is 1, `reg_oe[i]`=1, the synchronized `oe_n[i]`=0 and `pll_locked`=1. In every other case the lane is 0.
- R4: A change on `oe_n` reaches `dif_run` at the falling clock edge that follows the second rising edge after the change. The lane value is unchanged just after each rising edge, because run flags change only on falling edges.
- R5: After start, `ref_run` = `ref_oe` AND (synchronized `pwr_ok` OR `ref_pd_run`). `ref_drive` stays 1 through power-down.
- R6: `pll_locked` is sampled directly at each falling edge. While it is 0, every `dif_run` bit is 0 from the next falling edge on.
- R7: Strap encoding on `ss_strap`: 00 means level low, 01 means mid, and 1x means high. These are captured and read back on `ss_readback` as 00, 01 and 11 respectively.
- R8: When `sw_ss_en`=1, `ss_code` = `sw_ss_sel`, except that the reserved code 10 gives 00. When `sw_ss_en`=0, `ss_code` = `ss_readback`. `ss_code` is never 10.
- R9: When `pwr_ok` falls low after start, all lanes stop. When `pwr_ok` returns high, the lanes resume without capturing the strap again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output clock; all decisions are taken on its edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power-good (high) / power-down (low) pin, asynchronous |
| oe_n | input | N_DIF | Active-low enable pin per differential lane, asynchronous |
| reg_oe | input | N_DIF | Register enable bit per lane |
| pll_locked | input | 1 | PLL lock flag |
| ref_oe | input | 1 | Register enable for the reference output |
| ref_pd_run | input | 1 | Reference keeps running during power-down |
| ss_strap | input | 2 | Tri-level spread strap: 00 low, 01 mid, 1x high |
| sw_ss_en | input | 1 | Software spread override enable |
| sw_ss_sel | input | 2 | Software spread code |
| dif_run | output | N_DIF | Per-lane run flag (0 = both legs low) |
| ref_run | output | 1 | Reference toggles when 1, low when 0 while driven |
| ref_drive | output | 1 | Reference driver enabled (0 = not driven) |
| ss_readback | output | 2 | Captured strap value |
| ss_code | output | 2 | Applied spread: 00 off, 01 -0.25%, 11 -0.5% |

## Verification
The case most likely to go wrong is an enable pin that finishes its synchronization on the same falling edge at which the PLL lock flag drops. The bench releases `oe_n` right after a rising edge. Just after the second rising edge, it pulls `pll_locked` low, so both arrive at the same falling edge. The lane must stay low at that edge. Once lock returns, the lane must come up at the very next falling edge. The same kind of overlap between a power-down entry and a reference enable change is judged by checking `ref_run` against `ref_pd_run` while `pwr_ok` is low.

// File: rtl/ckout_pm_ctrl.sv
module ckout_pm_ctrl #(
  parameter int N_DIF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_ok,
  input  logic [N_DIF-1:0] oe_n,
  input  logic [N_DIF-1:0] reg_oe,
  input  logic             pll_locked,
  input  logic             ref_oe,
  input  logic             ref_pd_run,
  input  logic [1:0]       ss_strap,
  input  logic             sw_ss_en,
  input  logic [1:0]       sw_ss_sel,
  output logic [N_DIF-1:0] dif_run,
  output logic             ref_run,
  output logic             ref_drive,
  output logic [1:0]       ss_readback,
  output logic [1:0]       ss_code
);

  localparam logic [1:0] SS_OFF  = 2'b00;
  localparam logic [1:0] SS_MID  = 2'b01;
  localparam logic [1:0] SS_FULL = 2'b11;

  logic [N_DIF-1:0] oe_meta, oe_sync;
  logic             pg_meta, pg_sync;
  logic             started;
  logic [1:0]       strap_q;
  logic [1:0]       strap_dec;
  logic             lane_gate;
  logic             ref_want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_meta <= '1;
      oe_sync <= '1;
      pg_meta <= 1'b0;
      pg_sync <= 1'b0;
    end else begin
      oe_meta <= oe_n;
      oe_sync <= oe_meta;
      pg_meta <= pwr_ok;
      pg_sync <= pg_meta;
    end
  end

  assign strap_dec = ss_strap[1] ? SS_FULL : (ss_strap[0] ? SS_MID : SS_OFF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      strap_q <= SS_OFF;
    end else if (!started && pg_sync) begin
      started <= 1'b1;
      strap_q <= strap_dec;
    end
  end

  assign lane_gate = started & pg_sync & pll_locked;
  assign ref_want  = started & ref_oe & (pg_sync | ref_pd_run);

  genvar gi;
  generate
    for (gi = 0; gi < N_DIF; gi++) begin : g_lane
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) dif_run[gi] <= 1'b0;
        else        dif_run[gi] <= lane_gate & reg_oe[gi] & ~oe_sync[gi];
      end
    end
  endgenerate

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) ref_run <= 1'b0;
    else        ref_run <= ref_want;
  end

  assign ref_drive   = started;
  assign ss_readback = strap_q;
  assign ss_code     = sw_ss_en ? ((sw_ss_sel == 2'b10) ? SS_OFF : sw_ss_sel) : strap_q;

endmodule

// File: rtl/ckout_pm_ctrl_chk.sv
module ckout_pm_ctrl_chk #(
  parameter int N_DIF = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pll_locked,
  input logic [N_DIF-1:0] reg_oe,
  input logic             ref_oe,
  input logic [N_DIF-1:0] dif_run,
  input logic             ref_run,
  input logic             ref_drive,
  input logic [1:0]       ss_readback,
  input logic [1:0]       ss_code,
  input logic             started
);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_drive |-> (dif_run == '0) && !ref_run);

  a_r2_drive_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ref_drive |=> ref_drive && $stable(ss_readback));

  a_r3_reg_gate: assert property (@(negedge clk) disable iff (!rst_n)
    (dif_run & ~$past(reg_oe)) == '0);

  a_r3_needs_start: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(started) |-> dif_run == '0);

  a_r5_ref_gate: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(ref_oe) |-> !ref_run);

  a_r6_lock_loss: assert property (@(negedge clk) disable iff (!rst_n)
    !$past(pll_locked) |-> dif_run == '0);

  a_r8_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    ss_code != 2'b10);

endmodule

bind ckout_pm_ctrl ckout_pm_ctrl_chk #(.N_DIF(N_DIF)) u_chk (
  .clk(clk), .rst_n(rst_n), .pll_locked(pll_locked), .reg_oe(reg_oe),
  .ref_oe(ref_oe), .dif_run(dif_run), .ref_run(ref_run), .ref_drive(ref_drive),
  .ss_readback(ss_readback), .ss_code(ss_code), .started(started)
);

// File: tb/ckout_pm_ctrl_tb.sv
module ckout_pm_ctrl_tb;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n, pwr_ok, pll_locked, ref_oe, ref_pd_run, sw_ss_en;
  logic [N-1:0] oe_n, reg_oe, dif_run;
  logic [1:0] ss_strap, sw_ss_sel, ss_readback, ss_code;
  logic ref_run, ref_drive;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ckout_pm_ctrl #(.N_DIF(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .oe_n(oe_n), .reg_oe(reg_oe),
    .pll_locked(pll_locked), .ref_oe(ref_oe), .ref_pd_run(ref_pd_run),
    .ss_strap(ss_strap), .sw_ss_en(sw_ss_en), .sw_ss_sel(sw_ss_sel),
    .dif_run(dif_run), .ref_run(ref_run), .ref_drive(ref_drive),
    .ss_readback(ss_readback), .ss_code(ss_code));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic at_rise(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic after_fall();
    @(negedge clk);
    #1;
  endtask

  task automatic power_on(input logic [1:0] strap);
    rst_n = 0; pwr_ok = 0; ss_strap = strap;
    at_rise(2);
    rst_n = 1;
    at_rise(3);
    pwr_ok = 1;
    at_rise(4);
  endtask

  initial begin
    rst_n = 0; pwr_ok = 0; oe_n = '1; reg_oe = '1; pll_locked = 0;
    ref_oe = 1; ref_pd_run = 0; ss_strap = 2'b01; sw_ss_en = 0; sw_ss_sel = 2'b00;
    at_rise(3);
    rst_n = 1;
    at_rise(5);
    chk("R1 ref_drive", ref_drive, 0);
    chk("R1 ref_run", ref_run, 0);
    chk("R1 dif_run", dif_run, 0);
    chk("R1 readback", ss_readback, 0);
    oe_n = '0; pll_locked = 1;
    at_rise(5);
    chk("R1 dif before start", dif_run, 0);

    pwr_ok = 1;
    at_rise(4);
    chk("R2 ref_drive", ref_drive, 1);
    chk("R5 ref_run", ref_run, 1);
    chk("R3 all lanes", dif_run, 4'hF);
    chk("R7 mid readback", ss_readback, 2'b01);
    chk("R8 strap applied", ss_code, 2'b01);
    ss_strap = 2'b10;
    at_rise(4);
    chk("R2 strap not recaptured", ss_readback, 2'b01);

    // R3 sweep of pin and register enables
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        oe_n = a[N-1:0]; reg_oe = b[N-1:0];
        at_rise(3);
        chk("R3 sweep", dif_run, b[N-1:0] & ~a[N-1:0]);
      end
    end

    // R4 latency
    oe_n = '1; reg_oe = '1;
    at_rise(4);
    chk("R4 start off", dif_run, 0);
    oe_n = 4'b0101;
    @(posedge clk);
    after_fall();
    chk("R4 first fall", dif_run, 0);
    at_rise(1);
    chk("R4 not at rise", dif_run, 0);
    after_fall();
    chk("R4 second fall", dif_run, 4'b1010);
    oe_n = '1;
    at_rise(2);
    chk("R4 stop not at rise", dif_run, 4'b1010);
    after_fall();
    chk("R4 stop at fall", dif_run, 0);

    // R6 lock loss on same fall as enable arrival
    oe_n = '0;
    at_rise(2);
    pll_locked = 0;
    after_fall();
    chk("R6 coincident", dif_run, 0);
    at_rise(1);
    pll_locked = 1;
    after_fall();
    chk("R6 relock", dif_run, 4'hF);
    at_rise(1);
    pll_locked = 0;
    after_fall();
    chk("R6 loss", dif_run, 0);
    pll_locked = 1;
    at_rise(2);

    // R9 / R5 power-down
    pwr_ok = 0;
    at_rise(4);
    chk("R9 pd lanes", dif_run, 0);
    chk("R5 pd ref low", ref_run, 0);
    chk("R5 pd drive", ref_drive, 1);
    ref_pd_run = 1;
    after_fall();
    chk("R5 pd ref runs", ref_run, 1);
    ref_oe = 0;
    at_rise(1);
    after_fall();
    chk("R5 ref_oe off", ref_run, 0);
    ref_oe = 1; ref_pd_run = 0;
    pwr_ok = 1;
    at_rise(4);
    chk("R9 resume", dif_run, 4'hF);
    chk("R9 no recapture", ss_readback, 2'b01);
    chk("R5 ref back", ref_run, 1);

    // R8 override
    sw_ss_en = 1;
    for (int s = 0; s < 4; s++) begin
      sw_ss_sel = s[1:0];
      #1;
      chk("R8 override", ss_code, (s == 2) ? 2'b00 : s[1:0]);
    end
    sw_ss_en = 0;
    #1;
    chk("R8 override off", ss_code, 2'b01);

    // R7 strap decode
    for (int l = 0; l < 4; l++) begin
      power_on(l[1:0]);
      chk("R7 decode", ss_readback, (l >= 2) ? 2'b11 : l[1:0]);
      chk("R7 applied", ss_code, (l >= 2) ? 2'b11 : l[1:0]);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule